// File: doc/BRIEF.md
# Video Memory DMA Engine

This block carries out the bulk transfers a video controller needs. When the command decoder hands it a request and a transfer kind, it performs one of three operations. It can stream 16-bit words from system memory into a video memory, duplicate bytes from one place in video RAM to another, or paint a run of video RAM with a single byte. The source address and the length come from a snapshot of the DMA register bank. The destination start and the destination stride come from the decoder.

The engine handles one element per clock when its source keeps up. It shows a busy flag for the status word while it runs and returns to idle when the length is used up. Each write leaves through one registered write port. A pair flag on that port tells the memories whether the write carries two bytes (high byte at the address, low byte at the address plus one) or a single byte in the low lane.

Top module: `vdma_engine`

## Requirements
- R1: The source address is {src_hi[6:0], src_mid[7:0], src_lo[7:0], 1'b0}, a 24-bit even address, and every memory read is issued at an even address.
- R2: When src_hi[7] is 1, bit 23 of the source address is forced to 0; otherwise bit 23 equals src_hi[6].
- R3: The length is {len_hi, len_lo}, with len_hi as the upper byte. A request with length zero issues no read and no write, and busy stays low.
- R4: In memory mode (kind 1), each element writes the read word with wr_pair=1 at the current destination. The source then advances by 2, and a length L gives ceil(L/2) elements.
- R5: Only one memory read is outstanding at a time. mem_rd_req and mem_rd_addr hold until mem_rd_valid is high, and the word is written on the edge that ends the valid cycle.
- R6: In copy mode (kind 2), reads come from video RAM with one cycle of latency. The source is the low 16 bits of the R1 address and advances by 1 per byte. Each byte is written with wr_pair=0 and wr_data={8'h00, byte}.
- R7: In fill mode (kind 3), fill_byte is written with wr_pair=0 and wr_data={8'h00, fill_byte}, once per length unit.
- R8: After every write, the destination advances by dest_step modulo 2^16.
- R9: busy rises on the edge that accepts a request and falls on the edge that registers the last write. A fill of length N is busy for N cycles, a memory transfer with no stalls for ceil(N/2) cycles, and a copy for N+1 cycles.
- R10: A request with kind 0, or a request that arrives while busy, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start request, sampled while idle |
| req_kind | input | 2 | 0 none, 1 memory, 2 copy, 3 fill |
| src_hi | input | 8 | Source register, upper byte and bit-23 clear flag |
| src_mid | input | 8 | Source register, middle byte |
| src_lo | input | 8 | Source register, low byte |
| len_hi | input | 8 | Length, upper byte |
| len_lo | input | 8 | Length, lower byte |
| dest_base | input | 16 | First destination address |
| dest_step | input | 8 | Destination stride per write |
| fill_byte | input | 8 | Fill value |
| busy | output | 1 | Transfer active |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 24 | Memory read address |
| mem_rd_valid | input | 1 | Read data valid, completes the request |
| mem_rd_data | input | 16 | Read word |
| vram_rd_en | output | 1 | Video RAM read enable (copy) |
| vram_rd_addr | output | 16 | Video RAM read address |
| vram_rd_data | input | 8 | Video RAM read byte, one cycle after enable |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 16 | Write data |
| wr_pair | output | 1 | 1: two bytes at addr and addr+1; 0: low byte only |

## Verification
The hardest case to reach from the ports is a memory read held across stall cycles. In that case the request and address must stay frozen, and the count must advance exactly once per accepted word. The bench reaches it by letting its memory model answer only every third cycle. On a different run it answers every cycle, which exposes the back-to-back path. A second request is pulsed in the middle of a fill to show that it is dropped. Lengths of zero, one and above 255 exercise both length bytes and the end-of-run edge.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_MEM  = 2'd1,
    KIND_COPY = 2'd2,
    KIND_FILL = 2'd3
  } vdma_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vdma_state_e;
endpackage

// File: rtl/vdma_src_addr.sv
// Assembles the even source address from the three register bytes.
module vdma_src_addr #(
  parameter int REG_W = 8,
  localparam int SRC_W = 3 * REG_W
) (
  input  logic [REG_W-1:0] bank_hi,
  input  logic [REG_W-1:0] bank_mid,
  input  logic [REG_W-1:0] bank_lo,
  output logic [SRC_W-1:0] src_addr
);
  // top bit of bank_hi suppresses the top address bit
  assign src_addr = {bank_hi[REG_W-2] & ~bank_hi[REG_W-1],
                     bank_hi[REG_W-3:0], bank_mid, bank_lo, 1'b0};
endmodule

// File: rtl/vdma_read_port.sv
// Single-outstanding read requester toward system memory.
module vdma_read_port #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              more,
  input  logic              rd_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fire
);
  assign fire = rd_req & rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
    end else if (start) begin
      rd_req  <= 1'b1;
      rd_addr <= start_addr;
    end else if (fire) begin
      rd_addr <= rd_addr + ADDR_W'(2);
      if (!more) rd_req <= 1'b0;
    end
  end
endmodule

// File: rtl/vdma_write_stage.sv
// Output register for the target memory write port.
module vdma_write_stage #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              pair_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_pair
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_pair <= 1'b0;
    end else begin
      wr_en <= go;
      if (go) begin
        wr_addr <= addr_in;
        wr_data <= data_in;
        wr_pair <= pair_in;
      end
    end
  end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine #(
  parameter int REG_W  = 8,
  parameter int DEST_W = 16,
  parameter int STEP_W = 8,
  parameter int WORD_W = 16,
  localparam int SRC_W  = 3 * REG_W,
  localparam int LEN_W  = 2 * REG_W,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [1:0]        req_kind,
  input  logic [REG_W-1:0]  src_hi,
  input  logic [REG_W-1:0]  src_mid,
  input  logic [REG_W-1:0]  src_lo,
  input  logic [REG_W-1:0]  len_hi,
  input  logic [REG_W-1:0]  len_lo,
  input  logic [DEST_W-1:0] dest_base,
  input  logic [STEP_W-1:0] dest_step,
  input  logic [BYTE_W-1:0] fill_byte,
  output logic              busy,
  output logic              mem_rd_req,
  output logic [SRC_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              vram_rd_en,
  output logic [DEST_W-1:0] vram_rd_addr,
  input  logic [BYTE_W-1:0] vram_rd_data,
  output logic              wr_en,
  output logic [DEST_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_pair
);
  import vdma_pkg::*;

  vdma_state_e       st_q;
  vdma_kind_e        kind_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [DEST_W-1:0] dest_q;
  logic [STEP_W-1:0] step_q;
  logic [BYTE_W-1:0] fill_q;
  logic              vrd_en_q;
  logic [DEST_W-1:0] vrd_addr_q;
  logic              pipe_q;

  logic [SRC_W-1:0]  src_full;
  logic [LEN_W-1:0]  len_in;
  vdma_kind_e        kind_in;
  logic              accept;
  logic              mem_fire;
  logic              mem_more;
  logic              wr_go;
  logic [WORD_W-1:0] wr_data_n;
  logic              wr_pair_n;
  logic              finish;
  logic [DEST_W-1:0] dest_next;

  vdma_src_addr #(.REG_W(REG_W)) u_src (
    .bank_hi (src_hi),
    .bank_mid(src_mid),
    .bank_lo (src_lo),
    .src_addr(src_full)
  );

  assign len_in  = {len_hi, len_lo};
  assign kind_in = vdma_kind_e'(req_kind);
  assign accept  = (st_q == ST_IDLE) && req && (kind_in != KIND_NONE) && (len_in != '0);

  vdma_read_port #(.ADDR_W(SRC_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .start     (accept && (kind_in == KIND_MEM)),
    .start_addr(src_full),
    .more      (mem_more),
    .rd_valid  (mem_rd_valid),
    .rd_req    (mem_rd_req),
    .rd_addr   (mem_rd_addr),
    .fire      (mem_fire)
  );

  assign mem_more  = cnt_q > LEN_W'(2);
  assign dest_next = dest_q + DEST_W'(step_q);

  always_comb begin
    wr_go     = 1'b0;
    wr_data_n = '0;
    wr_pair_n = 1'b0;
    finish    = 1'b0;
    if (st_q == ST_RUN) begin
      case (kind_q)
        KIND_MEM: begin
          if (mem_fire) begin
            wr_go     = 1'b1;
            wr_data_n = mem_rd_data;
            wr_pair_n = 1'b1;
            finish    = !mem_more;
          end
        end
        KIND_COPY: begin
          if (pipe_q) begin
            wr_go     = 1'b1;
            wr_data_n = {{(WORD_W-BYTE_W){1'b0}}, vram_rd_data};
            finish    = !vrd_en_q;
          end
        end
        KIND_FILL: begin
          wr_go     = 1'b1;
          wr_data_n = {{(WORD_W-BYTE_W){1'b0}}, fill_q};
          finish    = (cnt_q == LEN_W'(1));
        end
        default: finish = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      kind_q     <= KIND_NONE;
      cnt_q      <= '0;
      dest_q     <= '0;
      step_q     <= '0;
      fill_q     <= '0;
      vrd_en_q   <= 1'b0;
      vrd_addr_q <= '0;
      pipe_q     <= 1'b0;
    end else if (accept) begin
      st_q       <= ST_RUN;
      kind_q     <= kind_in;
      cnt_q      <= len_in;
      dest_q     <= dest_base;
      step_q     <= dest_step;
      fill_q     <= fill_byte;
      vrd_en_q   <= (kind_in == KIND_COPY);
      vrd_addr_q <= src_full[DEST_W-1:0];
      pipe_q     <= 1'b0;
    end else if (st_q == ST_RUN) begin
      if (wr_go) dest_q <= dest_next;
      case (kind_q)
        KIND_MEM:  if (mem_fire && mem_more) cnt_q <= cnt_q - LEN_W'(2);
        KIND_FILL: cnt_q <= cnt_q - LEN_W'(1);
        KIND_COPY: begin
          if (vrd_en_q) begin
            cnt_q      <= cnt_q - LEN_W'(1);
            vrd_addr_q <= vrd_addr_q + DEST_W'(1);
            if (cnt_q == LEN_W'(1)) vrd_en_q <= 1'b0;
          end
        end
        default: ;
      endcase
      pipe_q <= vrd_en_q;
      if (finish) st_q <= ST_IDLE;
    end
  end

  assign busy         = (st_q == ST_RUN);
  assign vram_rd_en   = vrd_en_q;
  assign vram_rd_addr = vrd_addr_q;

  vdma_write_stage #(.ADDR_W(DEST_W), .DATA_W(WORD_W)) u_wr (
    .clk    (clk),
    .rst    (rst),
    .go     (wr_go),
    .addr_in(dest_q),
    .data_in(wr_data_n),
    .pair_in(wr_pair_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .wr_pair(wr_pair)
  );
endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk #(
  parameter int REG_W = 8,
  localparam int SRC_W = 3 * REG_W
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             mem_rd_req,
  input logic [SRC_W-1:0] mem_rd_addr,
  input logic             mem_rd_valid,
  input logic             vram_rd_en,
  input logic             wr_en
);
  assert_even_read_R1: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !mem_rd_addr[0]);

  assert_read_held_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_one_source_R6: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && vram_rd_en));

  assert_write_in_run_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(busy));

  assert_last_write_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> wr_en);

  assert_reads_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || vram_rd_en) |-> busy);
endmodule

bind vdma_engine vdma_engine_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/vdma_engine_test.sv
`timescale 1ns/1ps
module vdma_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [7:0]  src_hi = '0, src_mid = '0, src_lo = '0, len_hi = '0, len_lo = '0;
  logic [15:0] dest_base = '0;
  logic [7:0]  dest_step = '0, fill_byte = '0;
  logic        busy, mem_rd_req, mem_rd_valid = 1'b0;
  logic [23:0] mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic        vram_rd_en;
  logic [15:0] vram_rd_addr;
  logic [7:0]  vram_rd_data = '0;
  logic        wr_en, wr_pair;
  logic [15:0] wr_addr, wr_data;

  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    logic        pair;
    string       tag;
  } wr_item_t;

  wr_item_t    wq[$];
  logic [23:0] rq[$];
  int n_checks = 0;
  int n_fail = 0;
  int stall_mode = 0;
  int ph = 0;

  always #2.5 clk = ~clk;

  vdma_engine uut (
    .clk(clk), .rst(rst), .req(req), .req_kind(req_kind),
    .src_hi(src_hi), .src_mid(src_mid), .src_lo(src_lo),
    .len_hi(len_hi), .len_lo(len_lo), .dest_base(dest_base),
    .dest_step(dest_step), .fill_byte(fill_byte), .busy(busy),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .vram_rd_en(vram_rd_en), .vram_rd_addr(vram_rd_addr),
    .vram_rd_data(vram_rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_pair(wr_pair)
  );

  function automatic logic [15:0] mem_word(input logic [23:0] a);
    return {a[8:1] ^ 8'h3C, a[16:9] + a[7:0]};
  endfunction

  function automatic logic [7:0] vram_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // video RAM model: one cycle read latency
  always @(posedge clk) if (vram_rd_en) vram_rd_data <= vram_byte(vram_rd_addr);

  // system memory model with optional stalls, checks read addresses
  always @(negedge clk) begin
    ph = (ph + 1) % 3;
    if (!rst && mem_rd_req && (stall_mode == 0 || ph == 0)) begin
      logic [23:0] ea;
      mem_rd_valid = 1'b1;
      mem_rd_data  = mem_word(mem_rd_addr);
      if (rq.size() == 0) begin
        check(1'b0, "R10", "unexpected memory read", 48'(mem_rd_addr), 48'h0);
      end else begin
        ea = rq.pop_front();
        check(mem_rd_addr == ea, "R1", "read address", 48'(mem_rd_addr), 48'(ea));
      end
    end else begin
      mem_rd_valid = 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      wr_item_t e;
      if (wq.size() == 0) begin
        check(1'b0, "R3", "unexpected write", {15'h0, wr_pair, wr_addr, wr_data}, 48'h0);
      end else begin
        e = wq.pop_front();
        check(wr_addr == e.addr && wr_data == e.data && wr_pair == e.pair, e.tag,
              "write {pair,addr,data}", {15'h0, wr_pair, wr_addr, wr_data},
              {15'h0, e.pair, e.addr, e.data});
      end
    end
  end

  task automatic push_expect(input logic [1:0] kind, input logic [7:0] hi, input logic [7:0] mid,
                             input logic [7:0] lo, input logic [15:0] len, input logic [15:0] dest,
                             input logic [7:0] step, input logic [7:0] fill, input string tag);
    logic [23:0] src;
    src = {hi[7] ? 1'b0 : hi[6], hi[5:0], mid, lo, 1'b0};
    if (kind == 2'd1) begin
      for (int i = 0; i < (int'(len) + 1) / 2; i++) begin
        rq.push_back(24'(src + 24'(2 * i)));
        wq.push_back('{16'(dest + 16'(i) * 16'(step)), mem_word(24'(src + 24'(2 * i))), 1'b1, tag});
      end
    end else if (kind == 2'd2) begin
      for (int i = 0; i < int'(len); i++)
        wq.push_back('{16'(dest + 16'(i) * 16'(step)), {8'h00, vram_byte(16'(src[15:0] + 16'(i)))}, 1'b0, tag});
    end else if (kind == 2'd3) begin
      for (int i = 0; i < int'(len); i++)
        wq.push_back('{16'(dest + 16'(i) * 16'(step)), {8'h00, fill}, 1'b0, tag});
    end
  endtask

  task automatic drive_req(input logic [1:0] kind, input logic [7:0] hi, input logic [7:0] mid,
                           input logic [7:0] lo, input logic [15:0] len, input logic [15:0] dest,
                           input logic [7:0] step, input logic [7:0] fill);
    @(negedge clk);
    req = 1'b1; req_kind = kind; src_hi = hi; src_mid = mid; src_lo = lo;
    len_hi = len[15:8]; len_lo = len[7:0]; dest_base = dest; dest_step = step; fill_byte = fill;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_op(input int busy_seen, input int exp_busy, input string tag);
    repeat (3) @(negedge clk);
    check(wq.size() == 0, tag, "writes left over", 48'(wq.size()), 48'h0);
    check(rq.size() == 0, tag, "reads left over", 48'(rq.size()), 48'h0);
    if (exp_busy >= 0) check(busy_seen == exp_busy, "R9", "busy cycles", 48'(busy_seen), 48'(exp_busy));
  endtask

  task automatic run_op(input logic [1:0] kind, input logic [7:0] hi, input logic [7:0] mid,
                        input logic [7:0] lo, input logic [15:0] len, input logic [15:0] dest,
                        input logic [7:0] step, input logic [7:0] fill, input int exp_busy,
                        input string tag);
    int bc;
    bc = 0;
    push_expect(kind, hi, mid, lo, len, dest, step, fill, tag);
    drive_req(kind, hi, mid, lo, len, dest, step, fill);
    while (busy && bc < 5000) begin
      bc++;
      @(negedge clk);
    end
    finish_op(bc, exp_busy, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int bc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(!busy && !wr_en && !mem_rd_req && !vram_rd_en, "R9", "reset outputs",
          {44'h0, busy, wr_en, mem_rd_req, vram_rd_en}, 48'h0);

    // R7 fill, busy N cycles
    run_op(2'd3, 8'h00, 8'h00, 8'h00, 16'd5, 16'h0100, 8'h01, 8'hCD, 5, "R7");
    // R8 destination wraps with large stride
    run_op(2'd3, 8'h00, 8'h00, 8'h00, 16'd3, 16'hFFF0, 8'h20, 8'h11, 3, "R8");
    // R4 memory transfer, no stalls
    stall_mode = 0;
    run_op(2'd1, 8'h01, 8'h23, 8'h45, 16'd6, 16'h0200, 8'h02, 8'h00, 3, "R4");
    // R5 odd length with stalled reads
    stall_mode = 1;
    run_op(2'd1, 8'h02, 8'hA0, 8'h07, 16'd5, 16'h1000, 8'h04, 8'h00, -1, "R5");
    stall_mode = 0;
    // R2 bit 23 cleared by flag
    run_op(2'd1, 8'hC1, 8'h00, 8'h10, 16'd4, 16'h0300, 8'h02, 8'h00, 2, "R2");
    // R1 bit 23 from src_hi[6] when flag clear
    run_op(2'd1, 8'h41, 8'h7F, 8'hFF, 16'd2, 16'h0400, 8'h02, 8'h00, 1, "R1");
    // R6 copy, busy N+1 cycles
    run_op(2'd2, 8'h00, 8'h10, 8'h08, 16'd4, 16'h4000, 8'h01, 8'h00, 5, "R6");
    run_op(2'd2, 8'h05, 8'h3F, 8'hFE, 16'd1, 16'h5555, 8'h01, 8'h00, 2, "R6");
    // R3 zero length: no activity
    run_op(2'd1, 8'h01, 8'h02, 8'h03, 16'd0, 16'h0000, 8'h01, 8'h00, 0, "R3");
    run_op(2'd3, 8'h00, 8'h00, 8'h00, 16'd0, 16'h0000, 8'h01, 8'h77, 0, "R3");
    // R3 length above 255 uses the upper byte
    run_op(2'd3, 8'h00, 8'h00, 8'h00, 16'h0103, 16'h2000, 8'h01, 8'h9E, 259, "R3");
    // R10 kind 0 ignored
    run_op(2'd0, 8'h00, 8'h00, 8'h00, 16'd4, 16'h0000, 8'h01, 8'h55, 0, "R10");

    // R10 request during a busy fill is dropped
    push_expect(2'd3, 8'h00, 8'h00, 8'h00, 16'd6, 16'h3000, 8'h01, 8'hA5, "R10");
    drive_req(2'd3, 8'h00, 8'h00, 8'h00, 16'd6, 16'h3000, 8'h01, 8'hA5);
    drive_req(2'd1, 8'h01, 8'h00, 8'h00, 16'd4, 16'h7000, 8'h02, 8'h00);
    bc = 0;
    while (busy && bc < 5000) begin
      bc++;
      @(negedge clk);
    end
    finish_op(bc, -1, "R10");
    check(!busy && !mem_rd_req, "R10", "idle after dropped request",
          {46'h0, busy, mem_rd_req}, 48'h0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule